// File: doc/BRIEF.md
# Two-Channel Debug Break Sequencer

This block sits between two address-compare channels, A and B, and the processor's break input. On every cycle it takes one match pulse from each channel and decides whether to raise a user break request. A small register interface sets how the channels combine. They can act independently, or in order, where channel B only counts after channel A has matched. Channel B can also be made to wait for a programmed number of its own matches. Its break can be taken before the matching instruction runs, or held back until that instruction completes.

Software reaches three registers through a plain write strobe, a 2-bit address and a combinational read port. The registers are a control register, a 12-bit execution counter shown as a 16-bit register, and a sticky cause register. The break request is a pulse, high only in the cycles where a break is decided. Every input is a per-cycle level with no handshake, so the block never applies back-pressure: a match that arrives is evaluated in that same cycle.

Top module: `dbg_break_seq`

## Requirements
- R1: After reset, all three registers read 0 and brk_req is low.
- R2: With the order bit (control bit 0) clear, a match_a pulse raises brk_req in the same cycle. A channel B break taken before execution also raises brk_req in its own match cycle.
- R3: With the order bit set, match_a raises no break and arms the sequence. A match_b raises a break only when it comes in a later cycle than an arming A. When A and B match in the same cycle and the sequence was not already armed, no break is raised. A channel B break disarms the sequence, and this disarm overrides a match_a in the same cycle.
- R4: With counting on (control bit 1), each eligible B match decrements a nonzero count by one. The break fires on the match that takes the count from 1 to 0. A count of 0 gives no break and stays at 0.
- R5: The count register sits at address 1. Bits 15:12 always read 0 and their written values are dropped.
- R6: With the timing bit (control bit 2) set, a channel B break is deferred to the first insn_done strictly after the firing cycle. With the timing bit clear, the break is raised in the match cycle.
- R7: The control register sits at address 0. Bits 15:3 always read 0 and writes to them have no effect.
- R8: The cause register sits at address 2: bit 0 for channel A, bit 1 for channel B. Each bit is set when its channel raises brk_req and stays set. Writing 0 to a bit clears it and writing 1 leaves it. A new cause in the same cycle as a clearing write wins.
- R9: A write to the count register in the same cycle as a decrementing B match loads the written value.
- R10: Address 3 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| match_a | input | 1 | Channel A compare hit this cycle |
| match_b | input | 1 | Channel B compare hit this cycle |
| insn_done | input | 1 | Instruction-complete strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| brk_req | output | 1 | User break request pulse |

## Verification
On every cycle, the assertions check these rules:
- An independent A match always breaks.
- An unarmed sequence with nothing pending cannot break.
- Arming only follows an A match.
- The counter moves only by a load or by a single decrement.
- A deferred break with no pending entry stays quiet.
- A pending break is released on the completion strobe.
- A cause bit rises only after a break.

The following can only be shown by the bench's scenarios, where a cycle model is compared on every clock:
- The exact firing cycle at the end of a countdown.
- The same-cycle A-and-B case.
- The disarm-over-arm priority.
- Write-versus-decrement precedence.
- Masking of the register bits.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;
  localparam int REG_AW = 2;
  localparam int NCH    = 2;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL  = 2'd0,
    RA_COUNT = 2'd1,
    RA_CAUSE = 2'd2,
    RA_SPARE = 2'd3
  } reg_addr_e;

  localparam int CTRL_SEQ  = 0;
  localparam int CTRL_CNT  = 1;
  localparam int CTRL_POST = 2;
  localparam int CTRL_W    = 3;

  typedef struct packed {
    logic post_b;
    logic cnt_en;
    logic seq;
  } ctrl_t;
endpackage

// File: rtl/dbg_brk_arm.sv
module dbg_brk_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic seq,
  input  logic match_a,
  input  logic match_b,
  input  logic b_fire,
  output logic a_brk,
  output logic b_qual,
  output logic armed
);
  logic armed_d;

  // Order mode: A only arms, and a B break disarms (disarm beats a same-cycle A).
  assign armed_d = seq && !b_fire && (armed || match_a);
  assign a_brk   = !seq && match_a;
  assign b_qual  = match_b && (!seq || armed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= armed_d;
  end
endmodule

// File: rtl/dbg_brk_counter.sv
module dbg_brk_counter #(
  parameter int CNT_VALID_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [CNT_VALID_W-1:0] load_val,
  input  logic                   cnt_en,
  input  logic                   b_qual,
  output logic                   b_fire,
  output logic [CNT_VALID_W-1:0] cnt
);
  localparam logic [CNT_VALID_W-1:0] ONE  = CNT_VALID_W'(1);
  localparam logic [CNT_VALID_W-1:0] ZERO = '0;

  logic at_last, nonzero, dec;

  assign at_last = (cnt == ONE);
  assign nonzero = (cnt != ZERO);
  assign dec     = cnt_en && b_qual && nonzero;
  assign b_fire  = b_qual && (!cnt_en || at_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= ZERO;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - ONE;
  end
endmodule

// File: rtl/dbg_brk_timing.sv
module dbg_brk_timing (
  input  logic clk,
  input  logic rst_n,
  input  logic post,
  input  logic b_fire,
  input  logic insn_done,
  output logic b_brk,
  output logic pend
);
  logic pend_d;

  assign pend_d = (post && b_fire) || (pend && !insn_done);
  assign b_brk  = (!post && b_fire) || (pend && insn_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_d;
  end
endmodule

// File: rtl/dbg_brk_regs.sv
module dbg_brk_regs
  import dbg_brk_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CNT_VALID_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [REG_AW-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [NCH-1:0]            cause_set,
  input  logic [CNT_VALID_W-1:0]    cnt,
  output ctrl_t                     ctrl,
  output logic                      cnt_load,
  output logic [CNT_VALID_W-1:0]    cnt_load_val,
  output logic [NCH-1:0]            cause,
  output logic [DATA_W-1:0]         rdata
);
  logic wr_ctrl, wr_cause;
  logic unused_wdata_hi;

  assign wr_ctrl      = we && (addr == RA_CTRL);
  assign wr_cause     = we && (addr == RA_CAUSE);
  assign cnt_load     = we && (addr == RA_COUNT);
  assign cnt_load_val = wdata[CNT_VALID_W-1:0];
  assign unused_wdata_hi = ^wdata[DATA_W-1:CNT_VALID_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (wr_ctrl) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_cause
    logic keep;
    assign keep = !(wr_cause && !wdata[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause[i] <= 1'b0;
      else        cause[i] <= cause_set[i] || (cause[i] && keep);
    end
  end

  always_comb begin
    rdata = '0;
    unique case (reg_addr_e'(addr))
      RA_CTRL:  rdata = DATA_W'(ctrl);
      RA_COUNT: rdata = DATA_W'(cnt);
      RA_CAUSE: rdata = DATA_W'(cause);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/dbg_break_seq.sv
module dbg_break_seq
  import dbg_brk_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CNT_VALID_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              match_a,
  input  logic              match_b,
  input  logic              insn_done,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              brk_req
);
  ctrl_t                  ctrl;
  logic                   armed, a_brk, b_qual, b_fire, b_brk, pend;
  logic                   cnt_load;
  logic [CNT_VALID_W-1:0] cnt, cnt_load_val;
  logic [NCH-1:0]         cause;

  dbg_brk_regs #(.DATA_W(DATA_W), .CNT_VALID_W(CNT_VALID_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .cause_set({b_brk, a_brk}), .cnt(cnt), .ctrl(ctrl), .cnt_load(cnt_load),
    .cnt_load_val(cnt_load_val), .cause(cause), .rdata(reg_rdata)
  );

  dbg_brk_arm u_arm (
    .clk(clk), .rst_n(rst_n), .seq(ctrl.seq), .match_a(match_a), .match_b(match_b),
    .b_fire(b_fire), .a_brk(a_brk), .b_qual(b_qual), .armed(armed)
  );

  dbg_brk_counter #(.CNT_VALID_W(CNT_VALID_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_load_val),
    .cnt_en(ctrl.cnt_en), .b_qual(b_qual), .b_fire(b_fire), .cnt(cnt)
  );

  dbg_brk_timing u_tim (
    .clk(clk), .rst_n(rst_n), .post(ctrl.post_b), .b_fire(b_fire),
    .insn_done(insn_done), .b_brk(b_brk), .pend(pend)
  );

  assign brk_req = a_brk || b_brk;
endmodule

// File: rtl/dbg_break_seq_chk.sv
module dbg_break_seq_chk #(
  parameter int CNT_VALID_W = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   match_a,
  input logic                   insn_done,
  input logic                   brk_req,
  input logic                   seq,
  input logic                   post,
  input logic                   armed,
  input logic                   pend,
  input logic                   cnt_load,
  input logic [CNT_VALID_W-1:0] cnt,
  input logic [1:0]             cause
);
  // R2
  indep_a_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq && match_a) |-> brk_req);

  // R3
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq && !armed && !pend) |-> !brk_req);

  // R3
  arm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(match_a));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt) && !$past(cnt_load)) |-> (cnt == $past(cnt) - CNT_VALID_W'(1)));

  // R6
  post_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (post && !pend && (seq || !match_a)) |-> !brk_req);

  // R6
  post_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && insn_done) |-> brk_req);

  // R8
  cause_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cause[0]) || $rose(cause[1])) |-> $past(brk_req));
endmodule

bind dbg_break_seq dbg_break_seq_chk #(.CNT_VALID_W(CNT_VALID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .match_a(match_a), .insn_done(insn_done),
  .brk_req(brk_req), .seq(ctrl.seq), .post(ctrl.post_b), .armed(armed),
  .pend(pend), .cnt_load(cnt_load), .cnt(cnt), .cause(cause)
);

// File: tb/sim_dbg_break_seq.sv
module sim_dbg_break_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        match_a = 1'b0, match_b = 1'b0, insn_done = 1'b0, reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        brk_req;

  int    n_vec = 0, n_bad = 0;
  string tag = "R1";
  bit    finished = 0;
  logic        last_brk;
  logic [15:0] last_rd;

  // behavioural model state
  bit m_seq, m_cnten, m_post, m_armed, m_pend, m_fa, m_fb;
  int m_cnt;

  dbg_break_seq u0 (
    .clk(clk), .rst_n(rst_n), .match_a(match_a), .match_b(match_b),
    .insn_done(insn_done), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .brk_req(brk_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int model_rd(input int a);
    case (a)
      0: return (m_post << 2) | (m_cnten << 1) | m_seq;
      1: return m_cnt;
      2: return (m_fb << 1) | m_fa;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      {m_seq, m_cnten, m_post, m_armed, m_pend, m_fa, m_fb} = '0;
      m_cnt = 0;
    end else begin
      bit abrk, bq, bfire, bbrk, ebrk, clr;
      int erd;
      abrk  = !m_seq && match_a;
      bq    = match_b && (!m_seq || m_armed);
      bfire = bq && (!m_cnten || m_cnt == 1);
      bbrk  = (bfire && !m_post) || (m_pend && insn_done);
      ebrk  = abrk || bbrk;
      erd   = model_rd(int'(reg_addr));
      n_vec++;
      if (brk_req !== ebrk) begin
        n_bad++;
        $display("FAIL %s brk_req got %0b expected %0b at %0t", tag, brk_req, ebrk, $time);
      end
      n_vec++;
      if (reg_rdata !== 16'(erd)) begin
        n_bad++;
        $display("FAIL %s reg_rdata[a=%0d] got %h expected %h at %0t", tag, reg_addr,
                 reg_rdata, 16'(erd), $time);
      end
      clr    = reg_we && reg_addr == 2'd2;
      m_fa   = abrk || (m_fa && !(clr && !reg_wdata[0]));
      m_fb   = bbrk || (m_fb && !(clr && !reg_wdata[1]));
      m_armed = m_seq && !bfire && (m_armed || match_a);
      m_pend = (m_post && bfire) || (m_pend && !insn_done);
      if (reg_we && reg_addr == 2'd1) m_cnt = int'(reg_wdata & 16'h0FFF);
      else if (m_cnten && bq && m_cnt != 0) m_cnt = m_cnt - 1;
      if (reg_we && reg_addr == 2'd0) begin
        m_seq = reg_wdata[0]; m_cnten = reg_wdata[1]; m_post = reg_wdata[2];
      end
    end
  end

  task automatic cyc(input bit ma, input bit mb, input bit dn, input bit we,
                     input int a, input int wd);
    match_a = ma; match_b = mb; insn_done = dn; reg_we = we;
    reg_addr = 2'(a); reg_wdata = 16'(wd);
    @(negedge clk); #1;
    last_brk = brk_req; last_rd = reg_rdata;
    @(posedge clk); #1;
    match_a = 0; match_b = 0; insn_done = 0; reg_we = 0;
  endtask

  task automatic chk(input string t, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %0h expected %0h", t, got, exp);
    end
  endtask

  task automatic wr(input int a, input int wd);
    cyc(0, 0, 0, 1, a, wd);
  endtask

  task automatic rd_chk(input string t, input int a, input int exp);
    cyc(0, 0, 0, 0, a, 0);
    chk(t, int'(last_rd), exp);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    tag = "R1";
    rd_chk("R1 ctrl reset", 0, 0);
    rd_chk("R1 count reset", 1, 0);
    rd_chk("R1 cause reset", 2, 0);
    chk("R1 brk low", int'(last_brk), 0);

    tag = "R7";
    wr(0, 16'hFFFF);
    rd_chk("R7 ctrl masked", 0, 16'h0007);
    wr(0, 0);

    tag = "R10";
    wr(3, 16'hFFFF);
    rd_chk("R10 spare reads 0", 3, 0);
    rd_chk("R10 ctrl untouched", 0, 0);

    tag = "R2";
    cyc(1, 0, 0, 0, 2, 0); chk("R2 A breaks", int'(last_brk), 1);
    rd_chk("R8 cause A", 2, 1);
    cyc(0, 1, 0, 0, 2, 0); chk("R2 B breaks pre", int'(last_brk), 1);
    tag = "R8";
    rd_chk("R8 cause both", 2, 3);
    wr(2, 16'h0002);
    rd_chk("R8 clear A keep B", 2, 2);
    wr(2, 0);
    rd_chk("R8 clear all", 2, 0);
    cyc(1, 0, 0, 1, 2, 0);
    rd_chk("R8 set beats clear", 2, 1);
    wr(2, 0);

    tag = "R3";
    wr(0, 1);
    cyc(0, 1, 0, 0, 0, 0); chk("R3 B unarmed", int'(last_brk), 0);
    cyc(1, 1, 0, 0, 0, 0); chk("R3 A+B same cycle", int'(last_brk), 0);
    cyc(0, 1, 0, 0, 0, 0); chk("R3 B after A", int'(last_brk), 1);
    cyc(0, 1, 0, 0, 0, 0); chk("R3 disarmed", int'(last_brk), 0);
    cyc(1, 0, 0, 0, 0, 0); chk("R3 A no break in order mode", int'(last_brk), 0);
    cyc(1, 1, 0, 0, 0, 0); chk("R3 armed A+B", int'(last_brk), 1);
    cyc(0, 1, 0, 0, 0, 0); chk("R3 disarm beats A", int'(last_brk), 0);

    tag = "R4";
    wr(0, 2);
    wr(1, 3);
    cyc(0, 1, 0, 0, 0, 0); chk("R4 count 3->2", int'(last_brk), 0);
    rd_chk("R4 count reads 2", 1, 2);
    cyc(0, 1, 0, 0, 0, 0); chk("R4 count 2->1", int'(last_brk), 0);
    cyc(0, 1, 0, 0, 0, 0); chk("R4 count 1->0 fires", int'(last_brk), 1);
    rd_chk("R4 count at 0", 1, 0);
    cyc(0, 1, 0, 0, 0, 0); chk("R4 zero count no break", int'(last_brk), 0);
    rd_chk("R4 stays 0", 1, 0);

    tag = "R9";
    wr(1, 6);
    cyc(0, 1, 0, 1, 1, 5);
    rd_chk("R9 write beats decrement", 1, 5);

    tag = "R5";
    wr(1, 16'hFFFF);
    rd_chk("R5 upper masked", 1, 16'h0FFF);
    wr(1, 16'h1002);
    rd_chk("R5 drop bit 12", 1, 2);

    tag = "R6";
    wr(0, 4);
    cyc(0, 1, 0, 0, 0, 0); chk("R6 post defers", int'(last_brk), 0);
    cyc(0, 0, 0, 0, 0, 0); chk("R6 still waiting", int'(last_brk), 0);
    cyc(0, 0, 1, 0, 0, 0); chk("R6 released on done", int'(last_brk), 1);
    cyc(0, 0, 1, 0, 0, 0); chk("R6 single pulse", int'(last_brk), 0);
    cyc(0, 1, 1, 0, 0, 0); chk("R6 same-cycle done ignored", int'(last_brk), 0);
    cyc(0, 0, 1, 0, 0, 0); chk("R6 next done releases", int'(last_brk), 1);
    wr(0, 7);
    wr(1, 2);
    cyc(1, 0, 0, 0, 0, 0); chk("R6 R3 arm", int'(last_brk), 0);
    cyc(0, 1, 0, 0, 0, 0); chk("R6 R4 first count", int'(last_brk), 0);
    cyc(0, 1, 0, 0, 0, 0); chk("R6 R4 final count pending", int'(last_brk), 0);
    cyc(0, 0, 1, 0, 0, 0); chk("R6 combined release", int'(last_brk), 1);

    tag = "R2 R3 R4 R6 R8 mixed";
    for (int i = 0; i < 400; i++) begin
      bit w;
      int a, d;
      w = ($urandom % 8) == 0;
      a = $urandom % 4;
      d = (a == 1) ? $urandom % 5 : $urandom % 16'hFFFF;
      cyc($urandom % 3 == 0, $urandom % 2 == 0, $urandom % 3 == 0, w, a, d);
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog R1 got hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule